// File: doc/BRIEF.md
# Two-level I/O address translator

This block sits between DMA-capable devices and memory. It turns a device bus address into a physical address. Translation pages are 4 KB. The first level is a file of on-chip descriptor registers, one per 32 MB region of bus space. Each descriptor either points to a second-level table held in memory or maps the whole region as one big page. Second-level entries are fetched through a simple read port.

An 8-entry fully associative TLB keeps completed second-level translations, so repeated accesses to a page need no table walk. Only one walk is in flight at a time. The request port is held off with ready/valid backpressure while the walk runs.

Software programs the block through a write-only register port. The registers are:
- a command word holding the enable bit;
- a window-size code;
- the descriptor registers;
- an invalidate register, which drops every cached translation inside one 16 KB bus-address granule.

Top module: `io_xlate`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, mem_rd_valid is 0, translation is disabled, the window code is 0 and every descriptor reads as invalid.
- R2: While bit 8 of the command word (cfg_addr 0) is clear, every request is answered one cycle after acceptance with resp_paddr equal to the zero-extended bus address, resp_fault 0, resp_cached 0, and no memory read.
- R3: Window code bits [1:0] (cfg_addr 1) map as follows: 0 and 2 give 256 MB, 1 gives 2 GB, 3 gives 128 GB. A request at or above the window is passed through exactly as in R2, and a request below it is translated.
- R4: A write with cfg_addr bit 6 set loads descriptor cfg_addr[5:0]. In a descriptor, bit 30 is valid, bit 31 selects a big page and bits [29:0] hold a 4 KB frame number.
- R5: On a TLB miss under a valid table descriptor, the block reads memory at (frame << 12) + bus bits [24:12] × 4 and holds mem_rd_addr until mem_rd_ack. In the returned word, bit 31 is valid, bit 30 is cached and bits [29:0] are the page number. resp_paddr is {page, bus[11:0]}, and it appears one cycle after mem_rd_ack.
- R6: A request that hits the TLB is answered one cycle after acceptance with the cached page and flag, and makes no memory read.
- R7: While a walk is outstanding, req_ready is 0 and no second walk starts.
- R8: An invalid descriptor, an invalid second-level word, or a translated address at or above 2 GB gives resp_fault 1 with resp_paddr equal to the bus address. The TLB is not filled, so a repeat request walks again.
- R9: A big-page descriptor gives resp_paddr = {frame[29:13], bus[24:0]}, resp_cached = bit 1 and resp_prio = bit 0. It makes no memory read and does not use the TLB.
- R10: Writing value G to the invalidate register (cfg_addr 2) clears every TLB entry whose bus address bits [30:14] equal G. Entries in other granules stay.
- R11: The TLB holds 8 entries and is filled in strict round-robin order. The ninth distinct fill replaces the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register select (bit 6 set: descriptor index in [5:0]) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 40 | Device bus address |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_fault | output | 1 | Translation fault |
| resp_cached | output | 1 | Cached flag of the mapping |
| resp_prio | output | 1 | Priority flag of a big-page mapping |
| resp_paddr | output | 42 | Physical address, or bus address on fault or pass-through |
| mem_rd_valid | output | 1 | Second-level read request, held until acknowledged |
| mem_rd_addr | output | 42 | Byte address of the second-level word |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Second-level word |

## Verification
The bench counts memory reads for every request, so TLB faults are visible at the ports:
- A stale entry shows up on the next request to its page as a zero-read response with an old page number.
- A lost entry, or a wrong replacement slot, shows up as an unexpected memory read.
- An invalidate that misses its granule shows up the same way, on the first request to that granule afterwards.

A wrong walk state shows up within a few cycles, because the request port is held off:
- A state that never returns to idle leaves req_ready low, and the request times out.
- A state that leaves early lets a second request in while mem_rd_valid is still high.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
   localparam int unsigned PAGE_SHIFT     = 12;
   localparam int unsigned REGION_SHIFT   = 25;
   localparam int unsigned GRANULE_SHIFT  = 14;
   localparam int unsigned FRAME_FIELD_W  = 30;
   localparam int unsigned L1_VALID_BIT   = 30;
   localparam int unsigned L1_BIG_BIT     = 31;
   localparam int unsigned L1_CACHED_BIT  = 1;
   localparam int unsigned L1_PRIO_BIT    = 0;
   localparam int unsigned L2_VALID_BIT   = 31;
   localparam int unsigned L2_CACHED_BIT  = 30;
   localparam int unsigned CMD_ENABLE_BIT = 8;

   typedef enum logic [1:0] {
      CSEL_CMD    = 2'd0,
      CSEL_WINDOW = 2'd1,
      CSEL_INVAL  = 2'd2,
      CSEL_NONE   = 2'd3
   } csel_e;

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_BUSY = 1'b1
   } walk_state_e;

   // log2 of the translated window in bytes for a window code
   function automatic int unsigned window_log2(input logic [1:0] code);
      case (code)
         2'd1:    return 31;
         2'd3:    return 37;
         default: return 28;
      endcase
   endfunction
endpackage

// File: rtl/xlt_cfg.sv
module xlt_cfg
   import xlt_pkg::*;
#(
   parameter int unsigned L1_COUNT = 64,
   parameter int unsigned CFG_AW   = 7,
   parameter int unsigned GRAN_W   = 17
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [CFG_AW-1:0]           cfg_addr,
   input  logic [31:0]                 cfg_wdata,
   input  logic [$clog2(L1_COUNT)-1:0] l1_rd_idx,
   output logic                        xlt_en,
   output logic [1:0]                  win_code,
   output logic [31:0]                 l1_rd_entry,
   output logic                        inval_en,
   output logic [GRAN_W-1:0]           inval_granule
);
   localparam int unsigned L1_IDX_W = $clog2(L1_COUNT);

   if (CFG_AW != L1_IDX_W + 1) begin : g_bad_cfg_aw
      $error("xlt_cfg: CFG_AW must be one above the descriptor index width");
   end
   if (GRAN_W > 32) begin : g_bad_gran
      $error("xlt_cfg: granule field wider than a register");
   end

   logic [31:0] l1_q [L1_COUNT];
   logic        ctl_hit;
   csel_e       csel;

   assign ctl_hit = (cfg_addr[CFG_AW-2:2] == '0);
   assign csel    = ctl_hit ? csel_e'(cfg_addr[1:0]) : CSEL_NONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xlt_en        <= 1'b0;
         win_code      <= 2'd0;
         inval_en      <= 1'b0;
         inval_granule <= '0;
         for (int i = 0; i < int'(L1_COUNT); i++) l1_q[i] <= '0;
      end else begin
         inval_en <= 1'b0;
         if (cfg_we) begin
            if (cfg_addr[CFG_AW-1]) begin
               l1_q[cfg_addr[L1_IDX_W-1:0]] <= cfg_wdata;
            end else begin
               case (csel)
                  CSEL_CMD:    xlt_en   <= cfg_wdata[CMD_ENABLE_BIT];
                  CSEL_WINDOW: win_code <= cfg_wdata[1:0];
                  CSEL_INVAL: begin
                     inval_en      <= 1'b1;
                     inval_granule <= cfg_wdata[GRAN_W-1:0];
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign l1_rd_entry = l1_q[l1_rd_idx];

   // R10: an invalidate pulse follows exactly one write to the invalidate register
   assert_inval_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      inval_en |-> $past(cfg_we && !cfg_addr[CFG_AW-1] && csel == CSEL_INVAL));
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned TAG_W  = 19,
   parameter int unsigned DATA_W = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              inv_en,
   input  logic [TAG_W-3:0]  inv_granule,
   output logic [DEPTH-1:0]  vld_o
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("xlt_tlb: DEPTH must be a power of two of at least 2");
   end

   logic [TAG_W-1:0]  tag_q  [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [DEPTH-1:0]  vld_q, hit_vec, inv_vec;
   logic [PTR_W-1:0]  ptr_q;
   logic              fill_ok;

   for (genvar g = 0; g < int'(DEPTH); g++) begin : g_entry
      assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
      assign inv_vec[g] = vld_q[g] && (tag_q[g][TAG_W-1:2] == inv_granule);

      // R10: a matching entry is gone after the invalidate, unless refilled with another granule
      assert_inval_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (inv_en && inv_vec[g]) |=> (!vld_q[g] || tag_q[g][TAG_W-1:2] != $past(inv_granule)));
   end

   always_comb begin
      lk_data = '0;
      for (int i = 0; i < int'(DEPTH); i++)
         if (hit_vec[i]) lk_data = lk_data | data_q[i];
   end
   assign lk_hit  = |hit_vec;
   assign vld_o   = vld_q;
   assign fill_ok = fill_en && !(inv_en && fill_tag[TAG_W-1:2] == inv_granule);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         ptr_q <= '0;
         for (int i = 0; i < int'(DEPTH); i++) begin
            tag_q[i]  <= '0;
            data_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < int'(DEPTH); i++)
            if (inv_en && inv_vec[i]) vld_q[i] <= 1'b0;
         if (fill_ok) begin
            vld_q[ptr_q]  <= 1'b1;
            tag_q[ptr_q]  <= fill_tag;
            data_q[ptr_q] <= fill_data;
            ptr_q         <= ptr_q + 1'b1;
         end
      end
   end

   // R6: a page is never cached twice
   assert_tlb_unique_R6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
   // R11: each fill moves the replacement pointer by one slot
   assert_rr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fill_ok |=> ptr_q == $past(ptr_q) + 1'b1);
endmodule

// File: rtl/io_xlate.sv
module io_xlate
   import xlt_pkg::*;
#(
   parameter int unsigned BUS_AW    = 40,
   parameter int unsigned PA_W      = 42,
   parameter int unsigned L1_COUNT  = 64,
   parameter int unsigned TLB_DEPTH = 8,
   parameter int unsigned CFG_AW    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BUS_AW-1:0] req_addr,
   output logic              resp_valid,
   output logic              resp_fault,
   output logic              resp_cached,
   output logic              resp_prio,
   output logic [PA_W-1:0]   resp_paddr,
   output logic              mem_rd_valid,
   output logic [PA_W-1:0]   mem_rd_addr,
   input  logic              mem_rd_ack,
   input  logic [31:0]       mem_rd_data
);
   localparam int unsigned PPN_W     = PA_W - PAGE_SHIFT;
   localparam int unsigned L1_IDX_W  = $clog2(L1_COUNT);
   localparam int unsigned L2_IDX_W  = REGION_SHIFT - PAGE_SHIFT;
   localparam int unsigned SPAN_LOG2 = REGION_SHIFT + L1_IDX_W;
   localparam int unsigned TAG_W     = L1_IDX_W + L2_IDX_W;
   localparam int unsigned GRAN_W    = SPAN_LOG2 - GRANULE_SHIFT;
   localparam int unsigned DATA_W    = PPN_W + 1;

   if (BUS_AW <= SPAN_LOG2 || BUS_AW > PA_W) begin : g_bad_aw
      $error("io_xlate: bus width must exceed the descriptor span and fit the physical width");
   end
   if (PPN_W > FRAME_FIELD_W || PPN_W <= L2_IDX_W) begin : g_bad_pa
      $error("io_xlate: physical width does not match the frame field");
   end
   if ((1 << L1_IDX_W) != L1_COUNT) begin : g_bad_l1
      $error("io_xlate: descriptor count must be a power of two");
   end

   walk_state_e         st_q;
   logic [BUS_AW-1:0]   addr_q;
   logic [PA_W-1:0]     rd_addr_q;
   logic                xlt_en, inval_en, accept, in_win, in_span, bypass;
   logic [1:0]          win_code;
   logic [31:0]         l1_entry;
   logic [GRAN_W-1:0]   inval_granule;
   logic                tlb_hit, fill_en;
   logic [DATA_W-1:0]   tlb_data;
   logic [TLB_DEPTH-1:0] tlb_vld;
   logic [PA_W-1:0]     req_ext, big_paddr, walk_addr;

   xlt_cfg #(.L1_COUNT(L1_COUNT), .CFG_AW(CFG_AW), .GRAN_W(GRAN_W)) u_cfg (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
      .l1_rd_idx(req_addr[SPAN_LOG2-1:REGION_SHIFT]),
      .xlt_en, .win_code, .l1_rd_entry(l1_entry), .inval_en, .inval_granule
   );

   assign fill_en = (st_q == WALK_BUSY) && mem_rd_ack && mem_rd_data[L2_VALID_BIT];

   xlt_tlb #(.DEPTH(TLB_DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_tlb (
      .clk, .rst_n,
      .lk_tag(req_addr[SPAN_LOG2-1:PAGE_SHIFT]), .lk_hit(tlb_hit), .lk_data(tlb_data),
      .fill_en, .fill_tag(addr_q[SPAN_LOG2-1:PAGE_SHIFT]),
      .fill_data({mem_rd_data[L2_CACHED_BIT], mem_rd_data[PPN_W-1:0]}),
      .inv_en(inval_en), .inv_granule(inval_granule), .vld_o(tlb_vld)
   );

   assign req_ready = (st_q == WALK_IDLE);
   assign accept    = req_valid && req_ready;
   assign in_win    = ((req_addr >> window_log2(win_code)) == '0);
   assign in_span   = ((req_addr >> SPAN_LOG2) == '0);
   assign bypass    = !xlt_en || !in_win;
   assign req_ext   = PA_W'(req_addr);
   assign big_paddr = {l1_entry[PPN_W-1:L2_IDX_W], req_addr[REGION_SHIFT-1:0]};
   assign walk_addr = {l1_entry[PPN_W-1:0], {PAGE_SHIFT{1'b0}}}
                    + PA_W'({req_addr[REGION_SHIFT-1:PAGE_SHIFT], 2'b00});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= WALK_IDLE;
         addr_q      <= '0;
         rd_addr_q   <= '0;
         resp_valid  <= 1'b0;
         resp_fault  <= 1'b0;
         resp_cached <= 1'b0;
         resp_prio   <= 1'b0;
         resp_paddr  <= '0;
      end else begin
         resp_valid <= 1'b0;
         case (st_q)
            WALK_IDLE: if (accept) begin
               resp_prio <= 1'b0;
               if (bypass) begin
                  resp_valid <= 1'b1; resp_fault <= 1'b0; resp_cached <= 1'b0;
                  resp_paddr <= req_ext;
               end else if (!in_span || !l1_entry[L1_VALID_BIT]) begin
                  resp_valid <= 1'b1; resp_fault <= 1'b1; resp_cached <= 1'b0;
                  resp_paddr <= req_ext;
               end else if (l1_entry[L1_BIG_BIT]) begin
                  resp_valid  <= 1'b1; resp_fault <= 1'b0;
                  resp_cached <= l1_entry[L1_CACHED_BIT];
                  resp_prio   <= l1_entry[L1_PRIO_BIT];
                  resp_paddr  <= big_paddr;
               end else if (tlb_hit) begin
                  resp_valid  <= 1'b1; resp_fault <= 1'b0;
                  resp_cached <= tlb_data[PPN_W];
                  resp_paddr  <= {tlb_data[PPN_W-1:0], req_addr[PAGE_SHIFT-1:0]};
               end else begin
                  st_q      <= WALK_BUSY;
                  addr_q    <= req_addr;
                  rd_addr_q <= walk_addr;
               end
            end
            WALK_BUSY: if (mem_rd_ack) begin
               st_q       <= WALK_IDLE;
               resp_valid <= 1'b1;
               resp_prio  <= 1'b0;
               if (mem_rd_data[L2_VALID_BIT]) begin
                  resp_fault  <= 1'b0;
                  resp_cached <= mem_rd_data[L2_CACHED_BIT];
                  resp_paddr  <= {mem_rd_data[PPN_W-1:0], addr_q[PAGE_SHIFT-1:0]};
               end else begin
                  resp_fault  <= 1'b1;
                  resp_cached <= 1'b0;
                  resp_paddr  <= PA_W'(addr_q);
               end
            end
            default: st_q <= WALK_IDLE;
         endcase
      end
   end

   assign mem_rd_valid = (st_q == WALK_BUSY);
   assign mem_rd_addr  = rd_addr_q;

   // R7: no request is taken while a walk is outstanding
   assert_walk_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> !req_ready);
   // R5: the walk read address is held until acknowledged
   assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));
   // R6: a response always follows an acceptance or a walk completion
   assert_resp_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> ($past(req_valid && req_ready) || $past(mem_rd_valid && mem_rd_ack)));
   // R8: a fault never adds a TLB entry
   assert_fault_nofill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_fault) |-> ($countones(tlb_vld) <= $countones($past(tlb_vld))));
endmodule

// File: tb/io_xlate_bench.sv
module io_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [6:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [39:0] req_addr = '0;
   logic        resp_valid, resp_fault, resp_cached, resp_prio;
   logic [41:0] resp_paddr;
   logic        mem_rd_valid;
   logic [41:0] mem_rd_addr;
   logic        mem_rd_ack = 1'b0;
   logic [31:0] mem_rd_data = '0;

   int checks = 0, errors = 0, rd_cnt = 0, mem_lat = 0, cyc = 0, stall_bad = 0;
   logic [41:0] last_rd_addr = '0;

   always #10 clk = ~clk;

   io_xlate u_io_xlate (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
      .req_valid, .req_ready, .req_addr,
      .resp_valid, .resp_fault, .resp_cached, .resp_prio, .resp_paddr,
      .mem_rd_valid, .mem_rd_addr, .mem_rd_ack, .mem_rd_data
   );

   // second-level table contents: word index w; invalid when w[7:0]==7
   function automatic logic [31:0] l2_word(input logic [41:0] a);
      logic [31:0] w;
      w = a[33:2];
      if (w[7:0] == 8'h07) return 32'h0;
      return 32'h8000_0000 | (w[0] ? 32'h4000_0000 : 32'h0) | (32'h0003_0000 + {16'h0, w[15:0]});
   endfunction

   always @(posedge clk) begin
      mem_rd_ack <= 1'b0;
      if (mem_rd_valid && !mem_rd_ack) begin
         if (mem_lat == 1) begin
            mem_rd_ack   <= 1'b1;
            mem_rd_data  <= l2_word(mem_rd_addr);
            last_rd_addr <= mem_rd_addr;
            rd_cnt       <= rd_cnt + 1;
            mem_lat      <= 0;
         end else mem_lat <= mem_lat + 1;
      end
   end

   task automatic summary_and_finish();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         summary_and_finish();
      end
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic do_req(input logic [39:0] a, output logic f, output logic c, output logic p,
                         output logic [41:0] pa, output int nrd, output int lat);
      int  r0;
      bit  got;
      @(negedge clk);
      r0 = rd_cnt; req_addr = a; req_valid = 1'b1;
      for (int k = 0; k < 50 && !req_ready; k++) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0; lat = 1; got = 1'b0;
      for (int k = 0; k < 50 && !got; k++) begin
         if (resp_valid) got = 1'b1;
         else begin
            if (mem_rd_valid && req_ready) stall_bad++;
            @(negedge clk);
            lat++;
         end
      end
      f = resp_fault; c = resp_cached; p = resp_prio; pa = resp_paddr;
      nrd = rd_cnt - r0;
      if (!got) begin
         checks++; errors++;
         $display("FAIL response timeout: got none expected one for %h", a);
      end
   endtask

   typedef struct packed {
      logic [39:0] addr;
      logic        fault;
      logic        cached;
      logic [41:0] paddr;
      logic [3:0]  reads;
   } vec_t;

   // window 2 GB, descriptors 0 (table), 1 (big cached), 2 (invalid), 63 (table)
   localparam vec_t VECS [9] = '{
      '{40'h00_0000_1234, 1'b0, 1'b1, 42'h000_3000_1234, 4'd1}, // R5 walk, odd word cached
      '{40'h00_0000_1ABC, 1'b0, 1'b1, 42'h000_3000_1ABC, 4'd0}, // R6 hit
      '{40'h00_0000_2000, 1'b0, 1'b0, 42'h000_3000_2000, 4'd1}, // R5 uncached
      '{40'h00_0000_7010, 1'b1, 1'b0, 42'h000_0000_7010, 4'd1}, // R8 invalid second level
      '{40'h00_0000_7010, 1'b1, 1'b0, 42'h000_0000_7010, 4'd1}, // R8 not filled
      '{40'h00_0212_3456, 1'b0, 1'b1, 42'h000_4012_3456, 4'd0}, // R9 big page
      '{40'h00_0400_0000, 1'b1, 1'b0, 42'h000_0400_0000, 4'd0}, // R8 invalid descriptor
      '{40'h00_7E00_5008, 1'b0, 1'b1, 42'h000_3000_5008, 4'd1}, // R4 last descriptor
      '{40'h00_8000_0040, 1'b0, 1'b0, 42'h000_8000_0040, 4'd0}  // R3 beyond window
   };

   logic        f, c, p;
   logic [41:0] pa;
   int          nrd, lat;

   task automatic base_config();
      cfg_wr(7'h00, 32'h0000_0100);
      cfg_wr(7'h01, 32'h0000_0001);
      cfg_wr(7'h40, 32'h4000_0100);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 req_ready", 64'(req_ready), 64'd1);
      check("R1 resp_valid", 64'(resp_valid), 64'd0);
      check("R1 mem_rd_valid", 64'(mem_rd_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      do_req(40'h00_0000_1234, f, c, p, pa, nrd, lat);
      check("R1 disabled after reset paddr", 64'(pa), 64'h1234);
      check("R1 disabled after reset reads", 64'(nrd), 64'd0);

      base_config();
      cfg_wr(7'h41, 32'hC004_0002);
      cfg_wr(7'h7F, 32'h4000_0200);

      for (int i = 0; i < 9; i++) begin
         do_req(VECS[i].addr, f, c, p, pa, nrd, lat);
         check($sformatf("R3/R4/R5/R6/R8/R9 vec %0d fault", i), 64'(f), 64'(VECS[i].fault));
         check($sformatf("R3/R4/R5/R6/R8/R9 vec %0d cached", i), 64'(c), 64'(VECS[i].cached));
         check($sformatf("R3/R4/R5/R6/R8/R9 vec %0d paddr", i), 64'(pa), 64'(VECS[i].paddr));
         check($sformatf("R3/R4/R5/R6/R8/R9 vec %0d reads", i), 64'(nrd), 64'(VECS[i].reads));
         if (i == 1) check("R6 hit latency", 64'(lat), 64'd1);
         if (i == 7) check("R5 walk address", 64'(last_rd_addr), 64'h20_0014);
      end
      check("R7 no acceptance during walk", 64'(stall_bad), 64'd0);

      // R10: invalidate granule 0 keeps region 63 page, drops pages 1 and 2
      cfg_wr(7'h02, 32'h0);
      do_req(40'h00_7E00_5008, f, c, p, pa, nrd, lat);
      check("R10 other granule kept", 64'(nrd), 64'd0);
      check("R10 other granule paddr", 64'(pa), 64'h3000_5008);
      do_req(40'h00_0000_1234, f, c, p, pa, nrd, lat);
      check("R10 page 1 refetched", 64'(nrd), 64'd1);
      do_req(40'h00_0000_2000, f, c, p, pa, nrd, lat);
      check("R10 page 2 refetched", 64'(nrd), 64'd1);

      // R3 window 256 MB
      cfg_wr(7'h01, 32'h0);
      do_req(40'h00_1000_0000, f, c, p, pa, nrd, lat);
      check("R3 256MB bypass paddr", 64'(pa), 64'h1000_0000);
      check("R3 256MB bypass fault", 64'(f), 64'd0);
      do_req(40'h00_0212_3456, f, c, p, pa, nrd, lat);
      check("R3 256MB inside translated", 64'(pa), 64'h4012_3456);
      // R8 window 128 GB, beyond descriptor span
      cfg_wr(7'h01, 32'h3);
      do_req(40'h00_8000_0040, f, c, p, pa, nrd, lat);
      check("R8 beyond span fault", 64'(f), 64'd1);
      check("R8 beyond span paddr", 64'(pa), 64'h8000_0040);
      cfg_wr(7'h01, 32'h1);

      // R2 disabled: bit 8 clear even with other bits set
      cfg_wr(7'h00, 32'hFFFF_FEFF);
      do_req(40'h00_0000_1234, f, c, p, pa, nrd, lat);
      check("R2 pass paddr", 64'(pa), 64'h1234);
      check("R2 pass cached", 64'(c), 64'd0);
      check("R2 pass reads", 64'(nrd), 64'd0);
      check("R2 pass latency", 64'(lat), 64'd1);
      cfg_wr(7'h00, 32'h0000_0100);

      // R9 priority flag
      cfg_wr(7'h43, 32'hC004_0001);
      do_req(40'h00_0600_0010, f, c, p, pa, nrd, lat);
      check("R9 prio flag", 64'(p), 64'd1);
      check("R9 prio paddr", 64'(pa), 64'h4000_0010);
      check("R9 prio cached", 64'(c), 64'd0);

      // R11 round robin after a fresh reset
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 ready in reset", 64'(req_ready), 64'd1);
      rst_n = 1'b1;
      base_config();
      for (int k = 8; k <= 16; k++) begin
         do_req(40'(k) << 12, f, c, p, pa, nrd, lat);
         check($sformatf("R11 fill page %0d", k), 64'(nrd), 64'd1);
      end
      do_req(40'h00_0000_9000, f, c, p, pa, nrd, lat);
      check("R11 page 9 kept", 64'(nrd), 64'd0);
      check("R11 page 9 paddr", 64'(pa), 64'h3000_9000);
      do_req(40'h00_0000_8000, f, c, p, pa, nrd, lat);
      check("R11 page 8 evicted", 64'(nrd), 64'd1);
      do_req(40'h00_0001_0000, f, c, p, pa, nrd, lat);
      check("R11 page 16 kept", 64'(nrd), 64'd0);

      summary_and_finish();
   end
endmodule